// File: doc/BRIEF.md
# Per-Association Outgoing Sequence Number Allocator

This block holds one outgoing sequence counter for each of a small set of one-way security associations. The counters sit in a register array indexed by association number. A request names one association. One cycle later the block answers with the next sequence number for that association. In extended mode the answer is the full 64-bit value. In every mode it also gives the low 32 bits that are carried in the packet header. A counter starts at zero, so the first value issued is 1.

A counter never wraps. In narrow mode the largest value it issues is 2^32-1. In extended mode the largest is 2^64-1. When the largest value is issued, a sticky per-association exhaustion flag rises so that control logic can install a fresh association. After that, every request on that association gets an error response, and no value is issued. Installing an association uses the load port. The load port writes the counter's last-issued value (0 for a fresh association) and selects the mode. It also recomputes the exhaustion flag.

Each issued value is used as a per-packet cipher input. For that reason, no value may be issued twice under one installation.

Top module: `sa_seq_alloc`

## Requirements
- R1: After reset, every counter is 0, every association is in narrow mode, all `exhausted` bits are 0, and `resp_valid` is 0.
- R2: A request in cycle t produces `resp_valid`=1 in cycle t+1 and only then. On a fresh association the first value returned is 1.
- R3: Each association has its own counter. Requests to one association never change the values returned for another.
- R4: In narrow mode the largest value issued is 0xFFFF_FFFF. Issuing it sets that association's `exhausted` bit. The value 2^32 is never issued.
- R5: In extended mode `resp_seq` carries the full 64-bit value and counts straight across the 2^32 boundary. `resp_wire` always equals `resp_seq[31:0]`.
- R6: In extended mode the largest value issued is 0xFFFF_FFFF_FFFF_FFFF. Issuing it sets the `exhausted` bit.
- R7: A request on an exhausted association answers with `resp_err`=1, and `resp_seq` and `resp_wire` are both 0. The association's state stays unchanged, so later requests also fail.
- R8: A load sets the counter to `load_last` and the mode to `load_ext`. The next value issued is `load_last`+1. After the load, the `exhausted` bit is 1 in either of two cases: `load_last` is at or above the mode's largest value, or (in narrow mode) `load_last` exceeds 0xFFFF_FFFF.
- R9: Requests may arrive every cycle, for the same or different associations, with no stall. Back-to-back requests to one association return consecutive values.
- R10: When a load and a request name the same association in the same cycle, the request is served from the state before the load. The loaded state takes effect from the next cycle.
- R11: The `exhausted` bit stays set until a load names that association.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Allocation request strobe |
| req_sa | input | SA_W | Association index of the request |
| load_valid | input | 1 | Install/reload strobe |
| load_sa | input | SA_W | Association index to install |
| load_ext | input | 1 | 1 selects 64-bit extended numbering |
| load_last | input | 64 | Last-issued value to install (0 for a fresh association) |
| resp_valid | output | 1 | Response strobe, one cycle after a request |
| resp_err | output | 1 | Request refused: association exhausted |
| resp_seq | output | 64 | Issued sequence value (0 on error) |
| resp_wire | output | 32 | Low 32 bits of the issued value for the header |
| exhausted | output | NUM_SA | Sticky per-association exhaustion flags |

## Verification
Allocation and reload can name the same association in one cycle. The bench provokes this in two ways. First, it drives a load on an association that is mid-count together with a request on it. Second, it drives a load together with a request that issues an association's final legal value. A scoreboard model applies the request to the pre-load state and then applies the load. From this it expects the old sequence (and no error) for that request. It then checks that the next request restarts from the loaded value and that the exhaustion flag reflects the load, not the final issue.

// File: rtl/sa_seq_pkg.sv
package sa_seq_pkg;
    parameter int SEQ_W  = 64;
    parameter int WIRE_W = 32;

    localparam logic [SEQ_W-1:0] NARROW_MAX = {{(SEQ_W-WIRE_W){1'b0}}, {WIRE_W{1'b1}}};
    localparam logic [SEQ_W-1:0] WIDE_MAX   = {SEQ_W{1'b1}};

    typedef struct packed {
        logic [SEQ_W-1:0] cnt;
        logic             ext;
        logic             exh;
    } slot_t;

    typedef struct packed {
        logic             valid;
        logic             err;
        logic [SEQ_W-1:0] seq;
    } resp_t;

    function automatic logic [SEQ_W-1:0] limit_of(input logic ext);
        return ext ? WIDE_MAX : NARROW_MAX;
    endfunction
endpackage

// File: rtl/sa_seq_slot.sv
module sa_seq_slot
    import sa_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic             ld_ext,
    input  logic [SEQ_W-1:0] ld_last,
    input  logic             adv_en,
    output logic [SEQ_W-1:0] nxt_val,
    output logic             can_issue,
    output logic             exh_flag
);
    slot_t st_d, st_q;
    logic [SEQ_W-1:0] inc_val;
    logic             inc_last;

    always_comb begin
        inc_val  = st_q.cnt + 1'b1;
        inc_last = (inc_val == limit_of(st_q.ext));
        st_d     = st_q;
        if (ld_en) begin
            st_d.cnt = ld_last;
            st_d.ext = ld_ext;
            st_d.exh = ld_ext ? (ld_last == WIDE_MAX) : (ld_last >= NARROW_MAX);
        end else if (adv_en && !st_q.exh) begin
            st_d.cnt = inc_val;
            if (inc_last) begin
                st_d.exh = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nxt_val   = inc_val;
    assign can_issue = !st_q.exh;
    assign exh_flag  = st_q.exh;
endmodule

// File: rtl/sa_seq_resp.sv
module sa_seq_resp
    import sa_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              ok,
    input  logic [SEQ_W-1:0]  val,
    output logic              out_valid,
    output logic              out_err,
    output logic [SEQ_W-1:0]  out_seq,
    output logic [WIRE_W-1:0] out_wire
);
    resp_t r_d, r_q;

    always_comb begin
        r_d       = '0;
        r_d.valid = take;
        r_d.err   = take && !ok;
        r_d.seq   = (take && ok) ? val : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.valid;
    assign out_err   = r_q.err;
    assign out_seq   = r_q.seq;
    assign out_wire  = r_q.seq[WIRE_W-1:0];
endmodule

// File: rtl/sa_seq_alloc.sv
module sa_seq_alloc
    import sa_seq_pkg::*;
#(
    parameter int NUM_SA = 4,
    localparam int SA_W  = (NUM_SA > 1) ? $clog2(NUM_SA) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SA_W-1:0]   req_sa,
    input  logic              load_valid,
    input  logic [SA_W-1:0]   load_sa,
    input  logic              load_ext,
    input  logic [SEQ_W-1:0]  load_last,
    output logic              resp_valid,
    output logic              resp_err,
    output logic [SEQ_W-1:0]  resp_seq,
    output logic [WIRE_W-1:0] resp_wire,
    output logic [NUM_SA-1:0] exhausted
);
    logic [SEQ_W-1:0] slot_nxt [NUM_SA];
    logic [NUM_SA-1:0] slot_ok;
    logic [SEQ_W-1:0] sel_nxt;
    logic             sel_ok;

    for (genvar i = 0; i < NUM_SA; i++) begin : g_slot
        logic hit_req, hit_ld;
        assign hit_req = req_valid  && (req_sa  == SA_W'(i));
        assign hit_ld  = load_valid && (load_sa == SA_W'(i));

        sa_seq_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_en    (hit_ld),
            .ld_ext   (load_ext),
            .ld_last  (load_last),
            .adv_en   (hit_req),
            .nxt_val  (slot_nxt[i]),
            .can_issue(slot_ok[i]),
            .exh_flag (exhausted[i])
        );
    end

    always_comb begin
        sel_nxt = '0;
        sel_ok  = 1'b0;
        for (int k = 0; k < NUM_SA; k++) begin
            if (req_sa == SA_W'(k)) begin
                sel_nxt = slot_nxt[k];
                sel_ok  = slot_ok[k];
            end
        end
    end

    sa_seq_resp u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (req_valid),
        .ok       (sel_ok),
        .val      (sel_nxt),
        .out_valid(resp_valid),
        .out_err  (resp_err),
        .out_seq  (resp_seq),
        .out_wire (resp_wire)
    );
endmodule

// File: rtl/sa_seq_alloc_chk.sv
module sa_seq_alloc_chk
    import sa_seq_pkg::*;
#(
    parameter int NUM_SA = 4,
    localparam int SA_W  = (NUM_SA > 1) ? $clog2(NUM_SA) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [SA_W-1:0]   req_sa,
    input logic              load_valid,
    input logic [SA_W-1:0]   load_sa,
    input logic              resp_valid,
    input logic              resp_err,
    input logic [SEQ_W-1:0]  resp_seq,
    input logic [WIRE_W-1:0] resp_wire,
    input logic [NUM_SA-1:0] exhausted
);
    assert_resp_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    assert_err_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> (resp_seq == '0 && resp_wire == '0));
    assert_wire_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_err) |-> (resp_wire == resp_seq[WIRE_W-1:0]));
    assert_no_zero_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_err) |-> (resp_seq != '0));
    assert_refuse_exhausted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && exhausted[req_sa]) |=> (resp_valid && resp_err));

    for (genvar i = 0; i < NUM_SA; i++) begin : g_sticky
        assert_exh_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (exhausted[i] && !(load_valid && load_sa == SA_W'(i))) |=> exhausted[i]);
    end
endmodule

bind sa_seq_alloc sa_seq_alloc_chk #(.NUM_SA(NUM_SA)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_sa    (req_sa),
    .load_valid(load_valid),
    .load_sa   (load_sa),
    .resp_valid(resp_valid),
    .resp_err  (resp_err),
    .resp_seq  (resp_seq),
    .resp_wire (resp_wire),
    .exhausted (exhausted)
);

// File: tb/sa_seq_alloc_bench.sv
module sa_seq_alloc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSA = 4;
    localparam int SW = 2;
    localparam logic [63:0] NMAX = 64'h0000_0000_FFFF_FFFF;
    localparam logic [63:0] WMAX = 64'hFFFF_FFFF_FFFF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [SW-1:0] req_sa = '0;
    logic load_valid = 1'b0;
    logic [SW-1:0] load_sa = '0;
    logic load_ext = 1'b0;
    logic [63:0] load_last = '0;
    logic resp_valid, resp_err;
    logic [63:0] resp_seq;
    logic [31:0] resp_wire;
    logic [NSA-1:0] exhausted;

    always #(CLK_PERIOD/2) clk = ~clk;

    sa_seq_alloc #(.NUM_SA(NSA)) u_sa_seq_alloc (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_sa(req_sa),
        .load_valid(load_valid), .load_sa(load_sa),
        .load_ext(load_ext), .load_last(load_last),
        .resp_valid(resp_valid), .resp_err(resp_err),
        .resp_seq(resp_seq), .resp_wire(resp_wire),
        .exhausted(exhausted)
    );

    typedef struct {
        logic        err;
        logic [63:0] seq;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [63:0] m_cnt [NSA];
    logic        m_ext [NSA];
    logic        m_exh [NSA];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus; model applies request to pre-load state, then the load
    task automatic drive(input bit rv, input int sa, input bit lv, input int lsa,
                         input bit lext, input logic [63:0] llast, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid  = rv;
        req_sa     = SW'(sa);
        load_valid = lv;
        load_sa    = SW'(lsa);
        load_ext   = lext;
        load_last  = llast;
        if (rv) begin
            e.tag = tag;
            if (m_exh[sa]) begin
                e.err = 1'b1;
                e.seq = '0;
            end else begin
                e.err = 1'b0;
                e.seq = m_cnt[sa] + 64'd1;
                m_cnt[sa] = e.seq;
                if (e.seq == (m_ext[sa] ? WMAX : NMAX)) m_exh[sa] = 1'b1;
            end
            sb.push_back(e);
        end
        if (lv) begin
            m_cnt[lsa] = llast;
            m_ext[lsa] = lext;
            m_exh[lsa] = lext ? (llast == WMAX) : (llast >= NMAX);
        end
    endtask

    task automatic req(input int sa, input string tag);
        drive(1'b1, sa, 1'b0, 0, 1'b0, '0, tag);
    endtask

    task automatic load(input int sa, input bit ext, input logic [63:0] v, input string tag);
        drive(1'b0, 0, 1'b1, sa, ext, v, tag);
    endtask

    task automatic idle_check_exh(input string tag);
        logic [NSA-1:0] expv;
        @(negedge clk);
        req_valid = 1'b0;
        load_valid = 1'b0;
        for (int i = 0; i < NSA; i++) expv[i] = m_exh[i];
        check(exhausted == expv, tag, 64'(exhausted), 64'(expv));
    endtask

    // monitor: compare each response against the scoreboard front
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2 unexpected response", resp_seq, '0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(resp_err == e.err, {e.tag, " err"}, 64'(resp_err), 64'(e.err));
                check(resp_seq == e.seq, {e.tag, " seq"}, resp_seq, e.seq);
                check(resp_wire == e.seq[31:0], {e.tag, " R5 wire"}, 64'(resp_wire), 64'(e.seq[31:0]));
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NSA; i++) begin
            m_cnt[i] = '0; m_ext[i] = 1'b0; m_exh[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(resp_valid == 1'b0, "R1 resp_valid after reset", 64'(resp_valid), 64'd0);
        check(exhausted == '0, "R1 exhausted after reset", 64'(exhausted), 64'd0);

        // R2 / R9: first values and back-to-back on one association
        req(0, "R2 first value");
        req(0, "R9 consecutive");
        req(0, "R9 consecutive");
        // R3 / R9: interleaved associations
        req(1, "R3 sa1 first");
        req(2, "R3 sa2 first");
        req(1, "R3 sa1 second");
        req(0, "R3 sa0 unaffected");

        // R4 / R7 / R11: narrow limit
        load(3, 1'b0, 64'h0000_0000_FFFF_FFFD, "R8 load narrow");
        req(3, "R4 near limit");
        req(3, "R4 last narrow value");
        idle_check_exh("R4 exhaustion flag");
        req(3, "R7 refused");
        req(3, "R7 still refused");
        idle_check_exh("R11 flag sticky after refusals");

        // R5: extended mode crosses 2^32
        load(2, 1'b1, 64'h0000_0000_FFFF_FFFE, "R8 load ext");
        req(2, "R5 below boundary");
        req(2, "R5 across boundary");
        req(2, "R5 above boundary");

        // R6: extended limit
        load(1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFD, "R8 load ext near top");
        req(1, "R6 near top");
        req(1, "R6 last ext value");
        req(1, "R7 ext refused");
        idle_check_exh("R6 exhaustion flag");

        // R10: load and request on one association in one cycle
        drive(1'b1, 0, 1'b1, 0, 1'b0, 64'd0, "R10 served from old state");
        req(0, "R10 restart after load");
        // R10 with final legal value issued alongside reload
        load(2, 1'b0, 64'h0000_0000_FFFF_FFFE, "R8 load narrow near top");
        drive(1'b1, 2, 1'b1, 2, 1'b0, 64'd5, "R10 last value with reload");
        idle_check_exh("R10 load wins over exhaustion");
        req(2, "R10 continues from loaded value");

        // R8 / R11: reload clears and sets flags
        load(3, 1'b0, 64'd0, "R8 clear");
        idle_check_exh("R11 cleared by load");
        req(3, "R8 fresh after clear");
        load(0, 1'b0, NMAX, "R8 load at limit");
        load(1, 1'b0, 64'h0000_0001_0000_0000, "R8 load over narrow range");
        idle_check_exh("R8 flags from load value");
        req(0, "R8 refused after limit load");
        req(1, "R8 refused after oversize load");
        idle_check_exh("R11 flags still set");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R2 all responses seen", 64'(sb.size()), 64'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule